// File: doc/BRIEF.md
# Single-Precision Round-and-Pack Unit

This unit is the last stage of a single-precision floating-point datapath. An upstream adder or multiplier supplies three things: a sign, a signed biased exponent, and a 31-bit working significand. The unit applies one of five rounding modes to these, packs a 32-bit binary32 word, and reports overflow, underflow and inexact. Inputs and outputs are registered through a single stage, so a result appears one clock after its operands.

In the working significand, bit 30 is the hidden-one position and bit 7 is the result LSB. Bits 6..0 are the seven round bits. The exponent input is one less than the packed exponent field of a normal result: rounding adds the significand, hidden bit included, onto the exponent field, so a hidden one at bit 23 of the rounded value lifts the field by one. A negative exponent starts the subnormal path. On that path the significand is shifted right with sticky jamming before rounding. An optional flush-to-zero control replaces any such tiny result with a signed zero.

Top module: `fp32_round_pack`

## Requirements
- R1: Every output updates exactly one clock after its inputs. A clock edge with `rst_n` low clears `result_o` and all three flags. Outside overflow, the result sign bit 31 always equals the input sign.
- R2: Mode code 0 (nearest, ties to even) adds 0x40 at the round bits. When the round bits are exactly 0x40, the LSB of the rounded significand is cleared.
- R3: Mode code 1 (toward zero) adds nothing, so the round bits are truncated. The reserved codes 5, 6 and 7 behave the same as code 1.
- R4: Mode code 2 (down) adds 0x7F for a negative sign and nothing for a positive sign. Mode code 3 (up) adds 0x7F for a positive sign and nothing for a negative sign.
- R5: Mode code 4 (to odd) adds 0x7F when significand bit 7 is zero and nothing when it is one. An inexact result therefore always has result bit 0 set.
- R6: `inx_o` is set when any of the seven round bits is nonzero, evaluated after any subnormal shift. It is also set on overflow and on a flush. An exact input leaves all flags clear.
- R7: Overflow occurs when the exponent is above 253, or equals 253 and adding the increment carries out of significand bit 30. Overflow sets `ovf_o` and `inx_o`.
- R8: On overflow the result is infinity (field 0xFF, fraction zero) when the mode is not code 4 and the increment was nonzero. In every other case it is the largest finite magnitude, 0x7F7FFFFF, with the input sign.
- R9: A negative exponent E shifts the significand right by -E. Every bit shifted out is ORed into bit 0, and shifts of 31 or more leave only that sticky bit. The exponent field then becomes 0, and `unf_o` is set when any round bit is nonzero after the shift.
- R10: In mode code 4, the increment on the subnormal path is chosen from bit 7 of the shifted significand, not the original one.
- R11: With `ftz_i` high and a negative exponent, the result is a zero carrying the input sign, and both `unf_o` and `inx_o` are set.
- R12: A carry out of the rounded fraction propagates into the exponent field. This lets a subnormal round up to the smallest normal and a normal round up to the next binade. A rounded significand of zero forces the exponent field to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rnd_mode_i | input | 3 | Rounding mode code (0 even, 1 zero, 2 down, 3 up, 4 odd) |
| ftz_i | input | 1 | Flush tiny results to signed zero |
| sign_i | input | 1 | Sign of the value |
| exp_i | input | EXP_W | Signed exponent, one below the packed field for a normal value |
| sig_i | input | 31 | Working significand, hidden one at bit 30, round bits 6..0 |
| result_o | output | 32 | Packed binary32 result |
| ovf_o | output | 1 | Overflow flag |
| unf_o | output | 1 | Underflow flag |
| inx_o | output | 1 | Inexact flag |

## Verification
The properties assume that operands arrive in the form a real datapath produces. For a non-negative exponent, the significand is either zero or has bit 30 set. The exponent is never so large that it wraps the EXP_W-bit signed range. Under those conditions the overflow word, the odd-mode LSB and the flush result can be checked purely from the registered outputs and the inputs one cycle earlier. The stimulus table holds to the same contract. It covers every mode, each tie and half-way pattern, both overflow triggers, and shallow and deep subnormal shifts. One subnormal case is chosen so that bit 7 changes under the shift, which makes the odd-mode increment differ between the original and the shifted significand.

// File: rtl/fp32rp_pkg.sv
// Package: shared constants and mode encoding for the round-and-pack unit.
// Assumes binary32 output and a 31-bit working significand with 7 guard bits.
package fp32rp_pkg;

    localparam int SIG_W     = 31;            // working significand width
    localparam int GRD_W     = 7;             // round bits below the LSB
    localparam int FRAC_W    = 23;            // stored fraction width
    localparam int EXPF_W    = 8;             // packed exponent field width
    localparam int WORD_W    = 1 + EXPF_W + FRAC_W;
    localparam int RSIG_W    = SIG_W + 1 - GRD_W;   // rounded significand incl. carry
    localparam int OVF_EXP   = (1 << EXPF_W) - 3;   // 253: last exponent that may carry
    localparam logic [GRD_W-1:0] HALF_INC = GRD_W'(1) << (GRD_W - 1);
    localparam logic [GRD_W-1:0] FULL_INC = {GRD_W{1'b1}};

    typedef enum logic [2:0] {
        RM_NEAR_EVEN = 3'd0,
        RM_ZERO      = 3'd1,
        RM_DOWN      = 3'd2,
        RM_UP        = 3'd3,
        RM_ODD       = 3'd4
    } rmode_e;

endpackage

// File: rtl/fp32rp_incr.sv
// Increment selector: picks the amount added at the round bits.
// Assumes lsb_i is bit 7 of the significand that will actually be rounded.
module fp32rp_incr
    import fp32rp_pkg::*;
(
    input  logic [2:0]       mode_i,
    input  logic             sign_i,
    input  logic             lsb_i,
    output logic [GRD_W-1:0] inc_o,
    output logic             tie_even_o,
    output logic             odd_mode_o
);

    rmode_e mode;
    assign mode = rmode_e'(mode_i);

    // Decode mode into an increment; unknown codes truncate.
    always_comb begin
        inc_o      = '0;
        tie_even_o = 1'b0;
        odd_mode_o = 1'b0;
        case (mode)
            RM_NEAR_EVEN: begin
                inc_o      = HALF_INC;
                tie_even_o = 1'b1;
            end
            RM_DOWN:  inc_o = sign_i ? FULL_INC : '0;
            RM_UP:    inc_o = sign_i ? '0 : FULL_INC;
            RM_ODD: begin
                inc_o      = lsb_i ? '0 : FULL_INC;
                odd_mode_o = 1'b1;
            end
            default:  inc_o = '0;
        endcase
    end

endmodule

// File: rtl/fp32rp_jam_shift.sv
// Right shifter with sticky jamming for the subnormal path.
// Assumes amt_i is the magnitude of a negative exponent; amt >= W keeps only sticky.
module fp32rp_jam_shift #(
    parameter int W     = 31,
    parameter int AMT_W = 11
) (
    input  logic [W-1:0]     din_i,
    input  logic [AMT_W-1:0] amt_i,
    output logic [W-1:0]     dout_o
);

    logic lost;

    // Collect every bit shifted out and fold it into bit 0.
    always_comb begin
        lost = 1'b0;
        for (int i = 0; i < W; i++) begin
            if (i < int'(amt_i)) lost = lost | din_i[i];
        end
        if (int'(amt_i) >= W) begin
            dout_o = {{(W-1){1'b0}}, |din_i};
        end else begin
            dout_o = (din_i >> amt_i) | {{(W-1){1'b0}}, lost};
        end
    end

endmodule

// File: rtl/fp32rp_pack.sv
// Adds the increment, applies the tie-to-even correction and packs the word.
// Assumes exp_fld_i is already zero on the subnormal path.
module fp32rp_pack
    import fp32rp_pkg::*;
(
    input  logic              sign_i,
    input  logic [EXPF_W-1:0] exp_fld_i,
    input  logic [SIG_W-1:0]  sig_i,
    input  logic [GRD_W-1:0]  inc_i,
    input  logic              tie_even_i,
    output logic [WORD_W-1:0] word_o,
    output logic              rbits_nz_o,
    output logic              carry_o
);

    logic [SIG_W:0]        sum;
    logic [RSIG_W-1:0]     rsig;
    logic [EXPF_W-1:0]     exp_use;

    // Add the increment and keep the bits at and above the LSB.
    always_comb begin
        sum  = {1'b0, sig_i} + {{(SIG_W+1-GRD_W){1'b0}}, inc_i};
        rsig = sum[SIG_W:GRD_W];
        if (tie_even_i && (sig_i[GRD_W-1:0] == HALF_INC)) rsig[0] = 1'b0;
    end

    // Zero significand forces a zero exponent field.
    assign exp_use    = (rsig == '0) ? '0 : exp_fld_i;
    assign rbits_nz_o = |sig_i[GRD_W-1:0];
    assign carry_o    = sum[SIG_W];

    // Additive pack so a fraction carry lifts the exponent.
    assign word_o = {sign_i, {(WORD_W-1){1'b0}}}
                  + {1'b0, exp_use, {FRAC_W{1'b0}}}
                  + {{(WORD_W-RSIG_W){1'b0}}, rsig};

endmodule

// File: rtl/fp32_round_pack.sv
// Top: single-precision round-and-pack with one register stage.
// Assumes a non-negative exponent comes with a normalized (or zero) significand.
module fp32_round_pack
    import fp32rp_pkg::*;
#(
    parameter int EXP_W = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [2:0]           rnd_mode_i,
    input  logic                 ftz_i,
    input  logic                 sign_i,
    input  logic [EXP_W-1:0]     exp_i,
    input  logic [SIG_W-1:0]     sig_i,
    output logic [WORD_W-1:0]    result_o,
    output logic                 ovf_o,
    output logic                 unf_o,
    output logic                 inx_o
);

    localparam int AMT_W = EXP_W + 1;
    localparam logic [WORD_W-2:0] INF_MAG = {{EXPF_W{1'b1}}, {FRAC_W{1'b0}}};
    localparam logic [WORD_W-2:0] MAX_MAG = {{(EXPF_W-1){1'b1}}, 1'b0, {FRAC_W{1'b1}}};

    logic signed [EXP_W-1:0] exp_s;
    int                      exp_int;
    logic                    neg_exp;
    logic [AMT_W-1:0]        shamt;
    logic [SIG_W-1:0]        sig_shift;
    logic [SIG_W-1:0]        sig_use;
    logic [EXPF_W-1:0]       exp_fld;
    logic [GRD_W-1:0]        inc;
    logic                    tie_even;
    logic                    odd_mode;
    logic [WORD_W-1:0]       packed_word;
    logic                    rbits_nz;
    logic                    carry;
    logic                    ovf_n;
    logic                    to_inf;
    logic                    flush_hit;
    logic [WORD_W-1:0]       result_n;

    assign exp_s   = exp_i;
    assign exp_int = int'(exp_s);
    assign neg_exp = exp_s[EXP_W-1];
    assign shamt   = AMT_W'(-exp_int);

    fp32rp_jam_shift #(.W(SIG_W), .AMT_W(AMT_W)) u_shift (
        .din_i  (sig_i),
        .amt_i  (shamt),
        .dout_o (sig_shift)
    );

    // Subnormal path rounds the shifted significand with a zero exponent.
    assign sig_use = neg_exp ? sig_shift : sig_i;
    assign exp_fld = neg_exp ? '0 : exp_s[EXPF_W-1:0];

    // Single selector after the shift: odd mode sees the post-shift LSB.
    fp32rp_incr u_incr (
        .mode_i     (rnd_mode_i),
        .sign_i     (sign_i),
        .lsb_i      (sig_use[GRD_W]),
        .inc_o      (inc),
        .tie_even_o (tie_even),
        .odd_mode_o (odd_mode)
    );

    fp32rp_pack u_pack (
        .sign_i     (sign_i),
        .exp_fld_i  (exp_fld),
        .sig_i      (sig_use),
        .inc_i      (inc),
        .tie_even_i (tie_even),
        .word_o     (packed_word),
        .rbits_nz_o (rbits_nz),
        .carry_o    (carry)
    );

    // Overflow: exponent beyond the carry limit, or at it with a carry.
    assign ovf_n     = !neg_exp && ((exp_int > OVF_EXP) || ((exp_int == OVF_EXP) && carry));
    assign to_inf    = !odd_mode && (inc != '0);
    assign flush_hit = neg_exp && ftz_i;

    // Select the special words ahead of the normal packed value.
    always_comb begin
        if (ovf_n) begin
            result_n = {sign_i, to_inf ? INF_MAG : MAX_MAG};
        end else if (flush_hit) begin
            result_n = {sign_i, {(WORD_W-1){1'b0}}};
        end else begin
            result_n = packed_word;
        end
    end

    // Output register stage with synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_o <= '0;
            ovf_o    <= 1'b0;
            unf_o    <= 1'b0;
            inx_o    <= 1'b0;
        end else begin
            result_o <= result_n;
            ovf_o    <= ovf_n;
            unf_o    <= neg_exp && (ftz_i || rbits_nz);
            inx_o    <= ovf_n || flush_hit || rbits_nz;
        end
    end

endmodule

// File: rtl/fp32_round_pack_chk.sv
// Checker: temporal properties on the round-and-pack outputs.
// Assumes inputs follow the normalized-significand contract of the top.
module fp32_round_pack_chk #(
    parameter int EXP_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       rnd_mode_i,
    input logic             ftz_i,
    input logic             sign_i,
    input logic [EXP_W-1:0] exp_i,
    input logic [31:0]      result_o,
    input logic             ovf_o,
    input logic             unf_o,
    input logic             inx_o
);

    // R1: reset clears the outputs on the following cycle.
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (result_o == 32'h0 && !ovf_o && !unf_o && !inx_o));

    // R1: sign carried through outside overflow.
    a_r1_sign_follows: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !ovf_o) |-> (result_o[31] == $past(sign_i)));

    // R7: overflow always reports inexact.
    a_r7_ovf_inexact: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |-> inx_o);

    // R9: underflow always reports inexact.
    a_r9_unf_inexact: assert property (@(posedge clk) disable iff (!rst_n)
        unf_o |-> inx_o);

    // R8: overflow word is infinity or largest finite.
    a_r8_ovf_word: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |-> (result_o[30:0] == 31'h7F800000 || result_o[30:0] == 31'h7F7FFFFF));

    // R8: odd mode never overflows to infinity.
    a_r8_odd_saturates: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rnd_mode_i) == 3'd4 && ovf_o)
        |-> (result_o[30:0] == 31'h7F7FFFFF));

    // R5: inexact odd-mode result has its LSB set.
    a_r5_odd_lsb_set: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rnd_mode_i) == 3'd4
         && !($past(ftz_i) && $past($signed(exp_i) < 0)) && inx_o && !ovf_o)
        |-> result_o[0]);

    // R11: flush produces signed zero with both flags.
    a_r11_flush_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(ftz_i) && $past($signed(exp_i) < 0))
        |-> (result_o[30:0] == 31'h0 && unf_o && inx_o));

endmodule

bind fp32_round_pack fp32_round_pack_chk #(.EXP_W(EXP_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rnd_mode_i (rnd_mode_i),
    .ftz_i      (ftz_i),
    .sign_i     (sign_i),
    .exp_i      (exp_i),
    .result_o   (result_o),
    .ovf_o      (ovf_o),
    .unf_o      (unf_o),
    .inx_o      (inx_o)
);

// File: tb/fp32_round_pack_tb.sv
// Bench: vector table walked by one loop, then directed reset checks.
module fp32_round_pack_tb;

    localparam int EXP_W = 10;
    localparam int NVEC  = 29;

    typedef struct packed {
        logic [2:0]       mode;
        logic             ftz;
        logic             sign;
        logic [EXP_W-1:0] exp;
        logic [30:0]      sig;
        logic [31:0]      res;
        logic [2:0]       flg;   // {ovf, unf, inx}
        logic [3:0]       req;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{3'd0, 1'b0, 1'b0, 10'h07E, 31'h40000000, 32'h3F800000, 3'b000, 4'd2},  // R2 exact
        '{3'd0, 1'b0, 1'b0, 10'h07E, 31'h40000040, 32'h3F800000, 3'b001, 4'd2},  // R2 tie, even kept
        '{3'd0, 1'b0, 1'b0, 10'h07E, 31'h400000C0, 32'h3F800002, 3'b001, 4'd2},  // R2 tie, odd up
        '{3'd0, 1'b0, 1'b0, 10'h07E, 31'h4000003F, 32'h3F800000, 3'b001, 4'd2},  // R2 below half
        '{3'd0, 1'b0, 1'b0, 10'h07E, 31'h40000041, 32'h3F800001, 3'b001, 4'd2},  // R2 above half
        '{3'd1, 1'b0, 1'b0, 10'h07E, 31'h4000007F, 32'h3F800000, 3'b001, 4'd3},  // R3 truncate
        '{3'd7, 1'b0, 1'b0, 10'h07E, 31'h4000007F, 32'h3F800000, 3'b001, 4'd3},  // R3 reserved code
        '{3'd3, 1'b0, 1'b0, 10'h07E, 31'h40000001, 32'h3F800001, 3'b001, 4'd4},  // R4 up positive
        '{3'd3, 1'b0, 1'b1, 10'h07E, 31'h40000001, 32'hBF800000, 3'b001, 4'd4},  // R4 up negative
        '{3'd2, 1'b0, 1'b1, 10'h07E, 31'h40000001, 32'hBF800001, 3'b001, 4'd4},  // R4 down negative
        '{3'd2, 1'b0, 1'b0, 10'h07E, 31'h40000001, 32'h3F800000, 3'b001, 4'd4},  // R4 down positive
        '{3'd4, 1'b0, 1'b0, 10'h07E, 31'h40000001, 32'h3F800001, 3'b001, 4'd5},  // R5 odd from even
        '{3'd4, 1'b0, 1'b0, 10'h07E, 31'h40000081, 32'h3F800001, 3'b001, 4'd5},  // R5 already odd
        '{3'd4, 1'b0, 1'b0, 10'h07E, 31'h40000000, 32'h3F800000, 3'b000, 4'd6},  // R6 exact odd
        '{3'd0, 1'b0, 1'b0, 10'h07E, 31'h7FFFFFC0, 32'h40000000, 3'b001, 4'd12}, // R12 binade carry
        '{3'd0, 1'b0, 1'b0, 10'h0FE, 31'h40000000, 32'h7F800000, 3'b101, 4'd7},  // R7 exp above limit
        '{3'd1, 1'b0, 1'b0, 10'h0FE, 31'h40000000, 32'h7F7FFFFF, 3'b101, 4'd8},  // R8 zero-mode max
        '{3'd4, 1'b0, 1'b0, 10'h0FE, 31'h40000000, 32'h7F7FFFFF, 3'b101, 4'd8},  // R8 odd max
        '{3'd0, 1'b0, 1'b1, 10'h0FD, 31'h7FFFFFC0, 32'hFF800000, 3'b101, 4'd7},  // R7 carry at limit
        '{3'd0, 1'b0, 1'b0, 10'h0FD, 31'h7FFFFF80, 32'h7F7FFFFF, 3'b000, 4'd7},  // R7 limit, no carry
        '{3'd3, 1'b0, 1'b1, 10'h0FE, 31'h40000000, 32'hFF7FFFFF, 3'b101, 4'd8},  // R8 up negative
        '{3'd2, 1'b0, 1'b1, 10'h0FE, 31'h40000000, 32'hFF800000, 3'b101, 4'd8},  // R8 down negative
        '{3'd0, 1'b0, 1'b0, 10'h3FF, 31'h40000000, 32'h00400000, 3'b000, 4'd9},  // R9 exact subnormal
        '{3'd0, 1'b0, 1'b0, 10'h3FF, 31'h40000001, 32'h00400000, 3'b011, 4'd9},  // R9 sticky
        '{3'd4, 1'b0, 1'b0, 10'h3FF, 31'h40000080, 32'h00400001, 3'b011, 4'd10}, // R10 lsb moved
        '{3'd0, 1'b1, 1'b1, 10'h3FF, 31'h40000000, 32'h80000000, 3'b011, 4'd11}, // R11 flush
        '{3'd3, 1'b0, 1'b0, 10'h3D8, 31'h40000000, 32'h00000001, 3'b011, 4'd9},  // R9 deep shift
        '{3'd0, 1'b0, 1'b0, 10'h3FF, 31'h7FFFFFFF, 32'h00800000, 3'b011, 4'd12}, // R12 to min normal
        '{3'd0, 1'b0, 1'b0, 10'h032, 31'h00000000, 32'h00000000, 3'b000, 4'd6}   // R6 zero
    };

    logic             clk;
    logic             rst_n;
    logic [2:0]       rnd_mode_i;
    logic             ftz_i;
    logic             sign_i;
    logic [EXP_W-1:0] exp_i;
    logic [30:0]      sig_i;
    logic [31:0]      result_o;
    logic             ovf_o;
    logic             unf_o;
    logic             inx_o;

    int n_checks;
    int n_fail;
    bit done;

    fp32_round_pack #(.EXP_W(EXP_W)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .rnd_mode_i (rnd_mode_i),
        .ftz_i      (ftz_i),
        .sign_i     (sign_i),
        .exp_i      (exp_i),
        .sig_i      (sig_i),
        .result_o   (result_o),
        .ovf_o      (ovf_o),
        .unf_o      (unf_o),
        .inx_o      (inx_o)
    );

    // 50 MHz clock.
    initial clk = 1'b0;
    always #10 clk = ~clk;

    // Compare outputs against expectation and log a miscompare.
    task automatic check(input int req, input logic [31:0] exp_res, input logic [2:0] exp_flg);
        n_checks++;
        if (result_o !== exp_res || {ovf_o, unf_o, inx_o} !== exp_flg) begin
            n_fail++;
            $display("FAIL R%0d: got %h flags %b, expected %h flags %b",
                     req, result_o, {ovf_o, unf_o, inx_o}, exp_res, exp_flg);
        end
    endtask

    // Drive one operand set at a falling edge.
    task automatic drive(input vec_t v);
        rnd_mode_i = v.mode;
        ftz_i      = v.ftz;
        sign_i     = v.sign;
        exp_i      = v.exp;
        sig_i      = v.sig;
    endtask

    // Watchdog ends a hung run as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    // Main sequence: table walk, then reset checks.
    initial begin
        n_checks = 0;
        n_fail   = 0;
        done     = 1'b0;
        rst_n    = 1'b0;
        drive(VECS[2]);
        repeat (3) @(negedge clk);
        check(1, 32'h0, 3'b000);              // R1 reset state
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            drive(VECS[i]);
            @(negedge clk);                   // one register stage
            check(int'(VECS[i].req), VECS[i].res, VECS[i].flg);
        end

        // R1: mid-run reset clears a flagged result.
        @(negedge clk);
        drive(VECS[15]);
        @(negedge clk);
        check(7, 32'h7F800000, 3'b101);
        rst_n = 1'b0;
        @(negedge clk);
        check(1, 32'h0, 3'b000);
        rst_n = 1'b1;
        @(negedge clk);
        check(1, 32'h7F800000, 3'b101);       // R1 output follows held input again

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule